// File: doc/BRIEF.md
# Banked Program Counter Unit

This block produces the 12-bit instruction fetch address for a small 8-bit microcontroller core. It holds the program counter, a one-bit memory-bank latch that supplies the top address bit on jumps, and a flag that records whether an interrupt service routine is running. The instruction decoder drives it with one-cycle strobes. The strobes advance the counter, form a jump target, replace the low byte inside the current page, load a return address from the stack logic, or form a table-lookup address in the fixed lookup page.

The counter only moves inside an 11-bit window. Bit 11 changes only through a jump or a direct load. The bank latch is ignored while the service-routine flag is set, so any jump taken inside a handler lands in the lower 2 KiB half of program space. A table lookup does not disturb the program counter. It places its address on a separate output for one fetch.

Top module: `bpc_unit`

## Requirements
- R1: While reset is asserted, and after it is released until the first strobe, `fetch_addr`, `tbl_addr`, `mem_bank` and `in_isr` all read 0.
- R2: An increment alone adds one to `fetch_addr[10:0]` modulo 2048 and leaves bit 11 unchanged, so 0x7FF goes to 0x000 and 0xFFF goes to 0x800.
- R3: `bank1_sel` sets `mem_bank` and `bank0_sel` clears it. When both are high in the same cycle, the latch is set.
- R4: A jump outside a service routine loads `fetch_addr` with `{mem_bank, opnd_hi[2:0], opnd_lo[7:0]}`. The bank value used is the one held before that clock edge.
- R5: A jump taken while `in_isr` is 1 forms the same address with bit 11 forced to 0, whatever the bank latch holds.
- R6: `isr_enter` sets `in_isr` and `isr_exit` clears it. When both are high in the same cycle, the flag is set.
- R7: A page-local load replaces `fetch_addr[7:0]` with `opnd_lo` and keeps bits 11:8.
- R8: A table strobe sets `tbl_addr` to `{4'h3, opnd_lo}` on the next edge and leaves `fetch_addr` unchanged. `tbl_addr` holds its value until the next table strobe.
- R9: A load strobe copies `ld_addr` into `fetch_addr`.
- R10: When several strobes are high together, the priority is load, then jump, then page-local, then increment. With no strobe high, `fetch_addr` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| inc_en | input | 1 | Sequential fetch increment |
| jmp_en | input | 1 | Form a jump target from the operands |
| page_en | input | 1 | Replace the low byte within the current page |
| tbl_en | input | 1 | Form a lookup-page table address |
| ld_en | input | 1 | Load the return address |
| ld_addr | input | 12 | Return address from the stack path |
| opnd_lo | input | 8 | Low-byte operand |
| opnd_hi | input | 3 | Immediate high part for jumps |
| bank0_sel | input | 1 | Clear the bank latch |
| bank1_sel | input | 1 | Set the bank latch |
| isr_enter | input | 1 | Interrupt entry marker |
| isr_exit | input | 1 | Interrupt return marker |
| fetch_addr | output | 12 | Current program counter |
| tbl_addr | output | 12 | Last table-lookup address |
| mem_bank | output | 1 | Bank latch state |
| in_isr | output | 1 | Service-routine flag |

## Verification
Every result of this block is registered once. A strobe applied in one cycle shows up on `fetch_addr`, `tbl_addr`, `mem_bank` or `in_isr` after the next rising edge and not earlier. A jump uses the bank and interrupt state from before that edge, even when a bank or interrupt strobe arrives in the same cycle. The bench therefore drives each stimulus just after a falling edge and lets one rising edge pass. It compares all four outputs at the following falling edge against a model that applies the same one-edge rule. The reset synchronizer adds two edges after `rst_n` rises, so the bench waits those out before its first strobe.

// File: rtl/bpc_pkg.sv
package bpc_pkg;

  // Source of the next program counter value, chosen by priority
  typedef enum logic [2:0] {
    SRC_HOLD = 3'd0,
    SRC_INC  = 3'd1,
    SRC_PAGE = 3'd2,
    SRC_JUMP = 3'd3,
    SRC_LOAD = 3'd4
  } pc_src_e;

endpackage

// File: rtl/bpc_arb.sv
module bpc_arb
  import bpc_pkg::*;
(
  input  logic    inc_en,
  input  logic    jmp_en,
  input  logic    page_en,
  input  logic    ld_en,
  output pc_src_e src
);

  // Fixed priority: return load, jump, page-local, increment
  always_comb begin
    if (ld_en)        src = SRC_LOAD;
    else if (jmp_en)  src = SRC_JUMP;
    else if (page_en) src = SRC_PAGE;
    else if (inc_en)  src = SRC_INC;
    else              src = SRC_HOLD;
  end

endmodule

// File: rtl/bpc_next.sv
module bpc_next
  import bpc_pkg::*;
#(
  parameter int AW = 12,
  parameter int LW = 8,
  parameter int HW = 3
) (
  input  pc_src_e         src,
  input  logic [AW-1:0]   pc_q,
  input  logic [AW-1:0]   ld_addr,
  input  logic [LW-1:0]   opnd_lo,
  input  logic [HW-1:0]   opnd_hi,
  input  logic            bank_q,
  input  logic            isr_q,
  output logic [AW-1:0]   pc_d
);

  localparam int IW = AW - 1;   // width of the wrapping window
  localparam int UW = AW - LW;  // width of the page number

  logic [IW-1:0] win_inc;
  logic          top_bit;
  logic [AW-1:0] jump_tgt;
  logic [AW-1:0] page_tgt;

  always_comb begin
    win_inc  = pc_q[IW-1:0] + {{(IW-1){1'b0}}, 1'b1};
    // the bank bit is held low inside a service routine
    top_bit  = bank_q & ~isr_q;
    jump_tgt = {top_bit, opnd_hi, opnd_lo};
    page_tgt = {pc_q[AW-1 -: UW], opnd_lo};
    case (src)
      SRC_LOAD: pc_d = ld_addr;
      SRC_JUMP: pc_d = jump_tgt;
      SRC_PAGE: pc_d = page_tgt;
      SRC_INC:  pc_d = {pc_q[AW-1], win_inc};
      default:  pc_d = pc_q;
    endcase
  end

endmodule

// File: rtl/bpc_mode.sv
module bpc_mode (
  input  logic clk,
  input  logic rst_i_n,
  input  logic bank0_sel,
  input  logic bank1_sel,
  input  logic isr_enter,
  input  logic isr_exit,
  output logic bank_q,
  output logic isr_q
);

  logic bank_d, bank_we;
  logic isr_d, isr_we;

  always_comb begin
    bank_we = bank0_sel | bank1_sel;
    bank_d  = bank1_sel;
    isr_we  = isr_enter | isr_exit;
    isr_d   = isr_enter;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      bank_q <= 1'b0;
      isr_q  <= 1'b0;
    end else begin
      if (bank_we) bank_q <= bank_d;
      if (isr_we)  isr_q  <= isr_d;
    end
  end

  // R3
  bank_set_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    bank1_sel |=> bank_q);

  // R3
  bank_clr_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (bank0_sel && !bank1_sel) |=> !bank_q);

  // R6
  isr_flag_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (isr_exit && !isr_enter) |=> !isr_q);

  // R6
  isr_keep_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!isr_exit && !isr_enter) |=> $stable(isr_q));

endmodule

// File: rtl/bpc_tbl.sv
module bpc_tbl #(
  parameter int AW = 12,
  parameter int LW = 8,
  parameter logic [AW-LW-1:0] TBL_PAGE = 'h3
) (
  input  logic          clk,
  input  logic          rst_i_n,
  input  logic          tbl_en,
  input  logic [LW-1:0] opnd_lo,
  output logic [AW-1:0] tbl_q
);

  logic [AW-1:0] tbl_d;

  always_comb tbl_d = {TBL_PAGE, opnd_lo};

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)    tbl_q <= '0;
    else if (tbl_en) tbl_q <= tbl_d;
  end

  // R8
  tbl_form_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    tbl_en |=> (tbl_q[AW-1:LW] == TBL_PAGE) && (tbl_q[LW-1:0] == $past(opnd_lo)));

  // R8
  tbl_hold_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    !tbl_en |=> $stable(tbl_q));

endmodule

// File: rtl/bpc_unit.sv
module bpc_unit
  import bpc_pkg::*;
#(
  parameter int AW = 12,
  parameter int LW = 8,
  parameter int HW = 3,
  parameter logic [AW-LW-1:0] TBL_PAGE = 'h3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc_en,
  input  logic          jmp_en,
  input  logic          page_en,
  input  logic          tbl_en,
  input  logic          ld_en,
  input  logic [AW-1:0] ld_addr,
  input  logic [LW-1:0] opnd_lo,
  input  logic [HW-1:0] opnd_hi,
  input  logic          bank0_sel,
  input  logic          bank1_sel,
  input  logic          isr_enter,
  input  logic          isr_exit,
  output logic [AW-1:0] fetch_addr,
  output logic [AW-1:0] tbl_addr,
  output logic          mem_bank,
  output logic          in_isr
);

  localparam int IW = AW - 1;

  logic [1:0]    rst_sync;
  logic          rst_i_n;
  pc_src_e       src;
  logic [AW-1:0] pc_q, pc_d;
  logic          pc_we;
  logic          bank_q, isr_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  bpc_arb u_arb (
    .inc_en  (inc_en),
    .jmp_en  (jmp_en),
    .page_en (page_en),
    .ld_en   (ld_en),
    .src     (src)
  );

  bpc_next #(.AW(AW), .LW(LW), .HW(HW)) u_next (
    .src     (src),
    .pc_q    (pc_q),
    .ld_addr (ld_addr),
    .opnd_lo (opnd_lo),
    .opnd_hi (opnd_hi),
    .bank_q  (bank_q),
    .isr_q   (isr_q),
    .pc_d    (pc_d)
  );

  bpc_mode u_mode (
    .clk       (clk),
    .rst_i_n   (rst_i_n),
    .bank0_sel (bank0_sel),
    .bank1_sel (bank1_sel),
    .isr_enter (isr_enter),
    .isr_exit  (isr_exit),
    .bank_q    (bank_q),
    .isr_q     (isr_q)
  );

  bpc_tbl #(.AW(AW), .LW(LW), .TBL_PAGE(TBL_PAGE)) u_tbl (
    .clk     (clk),
    .rst_i_n (rst_i_n),
    .tbl_en  (tbl_en),
    .opnd_lo (opnd_lo),
    .tbl_q   (tbl_addr)
  );

  always_comb pc_we = (src != SRC_HOLD);

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)   pc_q <= '0;
    else if (pc_we) pc_q <= pc_d;
  end

  assign fetch_addr = pc_q;
  assign mem_bank   = bank_q;
  assign in_isr     = isr_q;

  // R9
  load_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    ld_en |=> fetch_addr == $past(ld_addr));

  // R4
  jump_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (jmp_en && !ld_en && !in_isr) |=>
      fetch_addr == {$past(mem_bank), $past(opnd_hi), $past(opnd_lo)});

  // R5
  isr_jump_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (jmp_en && !ld_en && in_isr) |=> !fetch_addr[AW-1]);

  // R7
  page_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (page_en && !ld_en && !jmp_en) |=>
      (fetch_addr[AW-1:LW] == $past(fetch_addr[AW-1:LW])) &&
      (fetch_addr[LW-1:0] == $past(opnd_lo)));

  // R2
  inc_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (inc_en && !ld_en && !jmp_en && !page_en) |=>
      (fetch_addr[IW-1:0] == $past(fetch_addr[IW-1:0]) + 1'b1) &&
      (fetch_addr[AW-1] == $past(fetch_addr[AW-1])));

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!inc_en && !ld_en && !jmp_en && !page_en) |=> $stable(fetch_addr));

endmodule

// File: tb/bpc_unit_tb.sv
`timescale 1ns/1ps
module bpc_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        inc_en, jmp_en, page_en, tbl_en, ld_en;
  logic [11:0] ld_addr;
  logic [7:0]  opnd_lo;
  logic [2:0]  opnd_hi;
  logic        bank0_sel, bank1_sel, isr_enter, isr_exit;
  logic [11:0] fetch_addr, tbl_addr;
  logic        mem_bank, in_isr;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  logic [11:0] e_pc, e_tbl;
  logic        e_bank, e_isr;

  always #2.5 clk = ~clk;

  bpc_unit u_dut (
    .clk(clk), .rst_n(rst_n), .inc_en(inc_en), .jmp_en(jmp_en),
    .page_en(page_en), .tbl_en(tbl_en), .ld_en(ld_en), .ld_addr(ld_addr),
    .opnd_lo(opnd_lo), .opnd_hi(opnd_hi), .bank0_sel(bank0_sel),
    .bank1_sel(bank1_sel), .isr_enter(isr_enter), .isr_exit(isr_exit),
    .fetch_addr(fetch_addr), .tbl_addr(tbl_addr), .mem_bank(mem_bank),
    .in_isr(in_isr)
  );

  task automatic chk(input string req, input string what,
                     input logic [11:0] act, input logic [11:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %03h expected %03h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    inc_en = 0; jmp_en = 0; page_en = 0; tbl_en = 0; ld_en = 0;
    ld_addr = '0; opnd_lo = '0; opnd_hi = '0;
    bank0_sel = 0; bank1_sel = 0; isr_enter = 0; isr_exit = 0;
  endtask

  // Drive one strobe set after a falling edge, model the next state,
  // let one rising edge pass, compare at the next falling edge.
  task automatic apply(input string req,
                       input bit ld, input bit jp, input bit pg, input bit ic,
                       input bit tb, input bit b0, input bit b1,
                       input bit ie, input bit ix,
                       input logic [11:0] la, input logic [2:0] hi,
                       input logic [7:0] lo);
    logic [11:0] n_pc;
    ld_en = ld; jmp_en = jp; page_en = pg; inc_en = ic; tbl_en = tb;
    bank0_sel = b0; bank1_sel = b1; isr_enter = ie; isr_exit = ix;
    ld_addr = la; opnd_hi = hi; opnd_lo = lo;
    if (ld)      n_pc = la;
    else if (jp) n_pc = {(e_bank & ~e_isr), hi, lo};
    else if (pg) n_pc = {e_pc[11:8], lo};
    else if (ic) n_pc = {e_pc[11], 11'(e_pc[10:0] + 11'd1)};
    else         n_pc = e_pc;
    e_pc = n_pc;
    if (tb) e_tbl = {4'h3, lo};
    if (b1) e_bank = 1'b1; else if (b0) e_bank = 1'b0;
    if (ie) e_isr = 1'b1; else if (ix) e_isr = 1'b0;
    @(posedge clk);
    @(negedge clk);
    idle_inputs();
    chk(req, "fetch_addr", fetch_addr, e_pc);
    chk(req, "mem_bank",   {11'd0, mem_bank}, {11'd0, e_bank});
    chk(req, "in_isr",     {11'd0, in_isr}, {11'd0, e_isr});
    chk(req, "tbl_addr",   tbl_addr, e_tbl);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    rst_n = 0;
    e_pc = '0; e_tbl = '0; e_bank = 0; e_isr = 0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1", "fetch_addr in reset", fetch_addr, 12'h000);
    chk("R1", "tbl_addr in reset", tbl_addr, 12'h000);
    chk("R1", "mem_bank in reset", {11'd0, mem_bank}, 12'h000);
    chk("R1", "in_isr in reset", {11'd0, in_isr}, 12'h000);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1", "fetch_addr after release", fetch_addr, 12'h000);
    chk("R1", "mem_bank after release", {11'd0, mem_bank}, 12'h000);

    // R10 hold with no strobe
    apply("R10", 0,0,0,0, 0,0,0, 0,0, 12'h000, 3'd0, 8'h00);

    // R2 increment wrap in both halves
    apply("R9", 1,0,0,0, 0,0,0, 0,0, 12'h7FD, 3'd0, 8'h00);
    for (int i = 0; i < 4; i++) apply("R2", 0,0,0,1, 0,0,0, 0,0, 12'h0, 3'd0, 8'h0);
    apply("R9", 1,0,0,0, 0,0,0, 0,0, 12'hFFE, 3'd0, 8'h00);
    for (int i = 0; i < 4; i++) apply("R2", 0,0,0,1, 0,0,0, 0,0, 12'h0, 3'd0, 8'h0);

    // R3 bank strobes
    apply("R3", 0,0,0,0, 0,0,1, 0,0, 12'h0, 3'd0, 8'h0);
    apply("R3", 0,0,0,0, 0,1,0, 0,0, 12'h0, 3'd0, 8'h0);
    apply("R3", 0,0,0,0, 0,1,1, 0,0, 12'h0, 3'd0, 8'h0);

    // R6 service flag, including both at once
    apply("R6", 0,0,0,0, 0,0,0, 1,0, 12'h0, 3'd0, 8'h0);
    apply("R6", 0,0,0,0, 0,0,0, 0,1, 12'h0, 3'd0, 8'h0);
    apply("R6", 0,0,0,0, 0,0,0, 1,1, 12'h0, 3'd0, 8'h0);
    apply("R6", 0,0,0,0, 0,0,0, 0,1, 12'h0, 3'd0, 8'h0);

    // R4 / R5 jump sweep over bank, service flag, high part, low bytes
    for (int bk = 0; bk < 2; bk++)
      for (int is = 0; is < 2; is++)
        for (int h = 0; h < 8; h++)
          for (int l = 0; l < 256; l += 51) begin
            apply("R3", 0,0,0,0, 0, bk == 0, bk == 1, is == 1, is == 0,
                  12'h0, 3'd0, 8'h0);
            apply(is ? "R5" : "R4", 0,1,0,0, 0,0,0, 0,0,
                  12'h0, 3'(h), 8'(l));
          end

    // R4 jump uses the bank value held before a same-cycle bank strobe
    apply("R3", 0,0,0,0, 0,1,0, 0,1, 12'h0, 3'd0, 8'h0);
    apply("R4", 0,1,0,0, 0,0,1, 0,0, 12'h0, 3'd5, 8'hC3);

    // R7 page-local sweep
    apply("R9", 1,0,0,0, 0,0,0, 0,0, 12'hA37, 3'd0, 8'h00);
    for (int l = 0; l < 256; l++) apply("R7", 0,0,1,0, 0,0,0, 0,0, 12'h0, 3'd0, 8'(l));

    // R8 table sweep, program counter untouched
    for (int l = 0; l < 256; l++) apply("R8", 0,0,0,0, 1,0,0, 0,0, 12'h0, 3'd0, 8'(255 - l));
    apply("R8", 0,0,0,1, 0,0,0, 0,0, 12'h0, 3'd0, 8'h11);

    // R10 priority over every mix of load/jump/page/increment
    for (int m = 0; m < 16; m++) begin
      apply("R9", 1,0,0,0, 0,0,1, 0,0, 12'h5F0, 3'd0, 8'h00);
      apply("R10", m[3], m[2], m[1], m[0], 0,0,0, 0,0,
            12'h9AB, 3'd6, 8'h4D);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule